// File: doc/BRIEF.md
# Microwire EEPROM Configuration Autoloader

This block brings up a chip's configuration from a serial EEPROM with no help from software. When reset is released, it waits a short fixed interval. It then raises the Microwire chip select and issues a single sequential READ starting at word 0. It clocks in the configuration words and one trailing user word. The serial clock is made by dividing the system clock. Command bits are launched on falling serial-clock edges, and EEPROM data is sampled on rising edges.

Each configuration word is held in a temporary word buffer and is also added into a running 16-bit checksum. When the stream ends, chip select drops and the sum is compared with a constant. If the sum matches, the buffered words are written out one per clock through a simple write port to the configuration registers. If it does not match, nothing is written and a failure flag is raised.

A shift-busy strobe frames the data phase so that outside logic can capture the serial stream. The user word appears on that stream but is never written inward. The interrupt output enable and the host-access enable both stay low until the load ends. After a failure, the interrupt enable stays low until a recovery pulse arrives.

Top module: `mw_cfg_loader`

## Requirements
- R1: Chip select rises exactly START_WAIT x HALF_DIV clocks after reset is released; that is 5 serial half-periods (2.5 serial periods) at the defaults. The serial clock toggles every HALF_DIV clocks and stays low whenever chip select is low.
- R2: The 17 configuration words (34 bytes) are written to cfg_addr 0..16 in ascending order, with word k carrying the k-th word read. The 18th word (2 user bytes) is never written.
- R3: No configuration write occurs before the whole stream has been read and chip select has dropped.
- R4: load_done is set, and the words are written, only if the 16-bit sum (modulo 2^16) of the 17 configuration words equals CHK_CONST (default 0xBABA). Otherwise load_fail is set and no write occurs. The two flags never assert together.
- R5: shift_busy is high across exactly the 288 rising serial-clock edges on which the 18 data words are sampled. Data on mw_do at those edges, taken MSB first, is the word stream.
- R6: irq_oe is low from reset. It goes high together with load_done on success. On failure it stays low until recover_i is pulsed.
- R7: host_en is low for the whole load and goes high once the load has ended, whether it passed or failed.
- R8: The command shifted out on mw_di is the 9 bits 1,1,0 followed by address 000000, MSB first. One dummy bit is then skipped before the first data bit.
- R9: With no EEPROM fitted (mw_do stuck high), every word reads as 0xFFFF, the checksum fails and no register is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release starts the load |
| mw_cs | output | 1 | Microwire chip select, active high |
| mw_sk | output | 1 | Microwire serial clock |
| mw_di | output | 1 | Serial data toward the EEPROM |
| mw_do | input | 1 | Serial data from the EEPROM |
| shift_busy | output | 1 | High while the data words are being shifted |
| cfg_we | output | 1 | Configuration register write strobe |
| cfg_addr | output | CA_W (5) | Configuration word index |
| cfg_wdata | output | WORD_W (16) | Configuration word value |
| load_done | output | 1 | Load finished with a good checksum |
| load_fail | output | 1 | Load finished with a bad checksum |
| recover_i | input | 1 | Recovery-done pulse that releases irq_oe after a failure |
| irq_oe | output | 1 | Interrupt pin output enable |
| host_en | output | 1 | Host register accesses and bus requests allowed |

## Verification
The bench targets the cycle where chip select rises. A design that counts one half-period too few or too many moves that edge and fails the exact count.

It also checks the command bits and the skipped dummy bit. An off-by-one at this point shifts every captured word by one bit, which shows up both in the snooped stream and in the scoreboard data.

Two images are sized to sit exactly at the checksum boundary: one sums to the constant and one misses it by one. A comparator that is wrong, or a commit that happens before the check, writes registers on the failing image. A missing EEPROM must fail without any write.

The user word must appear on the snoop path but must never reach the write port. The busy strobe must frame exactly 288 sampling edges: a strobe that opens on the dummy bit or closes early gives a different count.

// File: rtl/mwcl_pkg.sv
package mwcl_pkg;

    typedef enum logic [2:0] {
        ST_WAIT,
        ST_CMD,
        ST_DUMMY,
        ST_DATA,
        ST_CLOSE,
        ST_CHECK,
        ST_COMMIT,
        ST_END
    } ld_state_e;

    localparam logic [2:0] MW_READ_OP = 3'b110;

endpackage

// File: rtl/mwcl_sk_gen.sv
module mwcl_sk_gen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic rise,
    output logic fall
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ph;
    } sk_regs_t;

    sk_regs_t q, d;
    logic     tick;

    always_comb begin
        d    = q;
        tick = (q.cnt == CW'(HALF_DIV - 1));
        if (tick) begin
            d.cnt = '0;
            d.ph  = ~q.ph;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
        rise = tick & ~q.ph;
        fall = tick & q.ph;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/mwcl_word_buf.sv
module mwcl_word_buf #(
    parameter int DEPTH  = 17,
    parameter int WORD_W = 16,
    parameter int AW     = 5
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (we && (waddr == AW'(i))) mem[i] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (raddr == AW'(i)) rdata = mem[i];
        end
    end
endmodule

// File: rtl/mwcl_csum.sv
module mwcl_csum #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              add,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] sum
);
    logic [WORD_W-1:0] sum_q, sum_d;

    always_comb begin
        sum_d = sum_q;
        if (add) sum_d = sum_q + word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_d;
    end

    assign sum = sum_q;
endmodule

// File: rtl/mw_cfg_loader.sv
module mw_cfg_loader
    import mwcl_pkg::*;
#(
    parameter int                HALF_DIV   = 4,
    parameter int                START_WAIT = 5,
    parameter int                ADDR_W     = 6,
    parameter int                CFG_WORDS  = 17,
    parameter int                USER_WORDS = 1,
    parameter int                WORD_W     = 16,
    parameter logic [WORD_W-1:0] CHK_CONST  = 16'hBABA,
    localparam int               CA_W       = (CFG_WORDS > 1) ? $clog2(CFG_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mw_cs,
    output logic              mw_sk,
    output logic              mw_di,
    input  logic              mw_do,
    output logic              shift_busy,
    output logic              cfg_we,
    output logic [CA_W-1:0]   cfg_addr,
    output logic [WORD_W-1:0] cfg_wdata,
    output logic              load_done,
    output logic              load_fail,
    input  logic              recover_i,
    output logic              irq_oe,
    output logic              host_en
);
    localparam int TOT_WORDS = CFG_WORDS + USER_WORDS;
    localparam int CMD_LEN   = 3 + ADDR_W;
    localparam int BIT_MAX   = (WORD_W > CMD_LEN) ? WORD_W : CMD_LEN;
    localparam int BIT_W     = $clog2(BIT_MAX);
    localparam int WC_W      = (TOT_WORDS > 1) ? $clog2(TOT_WORDS) : 1;
    localparam int WAIT_W    = $clog2(START_WAIT + 1);

    typedef struct packed {
        ld_state_e          st;
        logic [WAIT_W-1:0]  wait_cnt;
        logic [BIT_W-1:0]   bit_cnt;
        logic [WC_W-1:0]    word_cnt;
        logic [CMD_LEN-1:0] cmd_sr;
        logic [WORD_W-1:0]  shreg;
        logic [CA_W-1:0]    cidx;
        logic               cs;
        logic               sk;
        logic               di;
        logic               busy;
        logic               we;
        logic [CA_W-1:0]    waddr;
        logic [WORD_W-1:0]  wdata;
        logic               done;
        logic               fail;
        logic               oe;
        logic               hosten;
    } ld_regs_t;

    ld_regs_t          q, d;
    logic              sk_rise, sk_fall;
    logic              buf_we, csum_add;
    logic [WORD_W-1:0] word_val, buf_rdata, csum_sum;

    mwcl_sk_gen #(.HALF_DIV(HALF_DIV)) u_sk (
        .clk  (clk),
        .rst_n(rst_n),
        .rise (sk_rise),
        .fall (sk_fall)
    );

    mwcl_word_buf #(.DEPTH(CFG_WORDS), .WORD_W(WORD_W), .AW(CA_W)) u_buf (
        .clk  (clk),
        .we   (buf_we),
        .waddr(CA_W'(q.word_cnt)),
        .wdata(word_val),
        .raddr(q.cidx),
        .rdata(buf_rdata)
    );

    mwcl_csum #(.WORD_W(WORD_W)) u_csum (
        .clk  (clk),
        .rst_n(rst_n),
        .add  (csum_add),
        .word (word_val),
        .sum  (csum_sum)
    );

    always_comb begin
        d        = q;
        d.we     = 1'b0;
        buf_we   = 1'b0;
        csum_add = 1'b0;
        word_val = {q.shreg[WORD_W-2:0], mw_do};

        // serial clock only runs once chip select is already high
        if (q.cs) begin
            if (sk_rise)      d.sk = 1'b1;
            else if (sk_fall) d.sk = 1'b0;
        end else begin
            d.sk = 1'b0;
        end

        unique case (q.st)
            ST_WAIT: begin
                if (sk_rise || sk_fall) begin
                    if (q.wait_cnt == WAIT_W'(START_WAIT - 1)) begin
                        d.cs      = 1'b1;
                        d.st      = ST_CMD;
                        d.cmd_sr  = {MW_READ_OP, {ADDR_W{1'b0}}};
                        d.bit_cnt = '0;
                    end else begin
                        d.wait_cnt = q.wait_cnt + 1'b1;
                    end
                end
            end
            ST_CMD: begin
                if (sk_fall) begin
                    d.di     = q.cmd_sr[CMD_LEN-1];
                    d.cmd_sr = q.cmd_sr << 1;
                end
                if (sk_rise) begin
                    if (q.bit_cnt == BIT_W'(CMD_LEN - 1)) begin
                        d.st      = ST_DUMMY;
                        d.bit_cnt = '0;
                    end else begin
                        d.bit_cnt = q.bit_cnt + 1'b1;
                    end
                end
            end
            ST_DUMMY: begin
                if (sk_fall) d.di = 1'b0;
                if (sk_rise) begin
                    d.st       = ST_DATA;
                    d.bit_cnt  = '0;
                    d.word_cnt = '0;
                end
            end
            ST_DATA: begin
                if (sk_fall) d.busy = 1'b1;
                if (sk_rise) begin
                    d.shreg = word_val;
                    if (q.bit_cnt == BIT_W'(WORD_W - 1)) begin
                        d.bit_cnt = '0;
                        if (q.word_cnt < WC_W'(CFG_WORDS)) begin
                            buf_we   = 1'b1;
                            csum_add = 1'b1;
                        end
                        if (q.word_cnt == WC_W'(TOT_WORDS - 1)) d.st = ST_CLOSE;
                        else d.word_cnt = q.word_cnt + 1'b1;
                    end else begin
                        d.bit_cnt = q.bit_cnt + 1'b1;
                    end
                end
            end
            ST_CLOSE: begin
                if (sk_fall) begin
                    d.cs   = 1'b0;
                    d.busy = 1'b0;
                    d.st   = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (csum_sum == CHK_CONST) begin
                    d.st   = ST_COMMIT;
                    d.cidx = '0;
                end else begin
                    d.fail   = 1'b1;
                    d.hosten = 1'b1;
                    d.st     = ST_END;
                end
            end
            ST_COMMIT: begin
                d.we    = 1'b1;
                d.waddr = q.cidx;
                d.wdata = buf_rdata;
                if (q.cidx == CA_W'(CFG_WORDS - 1)) begin
                    d.st     = ST_END;
                    d.done   = 1'b1;
                    d.oe     = 1'b1;
                    d.hosten = 1'b1;
                end else begin
                    d.cidx = q.cidx + 1'b1;
                end
            end
            ST_END: begin
                if (q.fail && recover_i) d.oe = 1'b1;
            end
            default: d.st = ST_END;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_WAIT;
        end else begin
            q <= d;
        end
    end

    assign mw_cs      = q.cs;
    assign mw_sk      = q.sk;
    assign mw_di      = q.di;
    assign shift_busy = q.busy;
    assign cfg_we     = q.we;
    assign cfg_addr   = q.waddr;
    assign cfg_wdata  = q.wdata;
    assign load_done  = q.done;
    assign load_fail  = q.fail;
    assign irq_oe     = q.oe;
    assign host_en    = q.hosten;
endmodule

// File: rtl/mwcl_chk.sv
module mwcl_chk #(
    parameter int CFG_WORDS = 17,
    parameter int CA_W      = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mw_cs,
    input logic            mw_sk,
    input logic            shift_busy,
    input logic            cfg_we,
    input logic [CA_W-1:0] cfg_addr,
    input logic            load_done,
    input logic            load_fail,
    input logic            irq_oe,
    input logic            host_en
);
    AST_SK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !mw_cs |-> !mw_sk);  // R1

    AST_WE_CFG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |-> (32'(cfg_addr) < CFG_WORDS));  // R2

    AST_WE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |-> !mw_cs);  // R3

    AST_DONE_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_done && load_fail));  // R4

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> load_done);  // R4

    AST_BUSY_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        shift_busy |-> mw_cs);  // R5

    AST_OE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        irq_oe |-> (load_done || load_fail));  // R6

    AST_HOST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        mw_cs |-> !host_en);  // R7
endmodule

bind mw_cfg_loader mwcl_chk #(.CFG_WORDS(CFG_WORDS), .CA_W(CA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mw_cs     (mw_cs),
    .mw_sk     (mw_sk),
    .shift_busy(shift_busy),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .load_done (load_done),
    .load_fail (load_fail),
    .irq_oe    (irq_oe),
    .host_en   (host_en)
);

// File: tb/mw_cfg_loader_tb.sv
module mw_cfg_loader_tb;
    localparam int          HALF  = 4;
    localparam int          START = 5;
    localparam int          CFG   = 17;
    localparam int          TOT   = 18;
    localparam logic [15:0] CHK   = 16'hBABA;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mw_cs, mw_sk, mw_di, mw_do;
    logic        shift_busy, cfg_we, load_done, load_fail, irq_oe, host_en;
    logic        recover_i = 1'b0;
    logic [4:0]  cfg_addr;
    logic [15:0] cfg_wdata;

    mw_cfg_loader #(.HALF_DIV(HALF), .START_WAIT(START), .CFG_WORDS(CFG),
                    .USER_WORDS(1), .CHK_CONST(CHK)) u_dut (
        .clk(clk), .rst_n(rst_n), .mw_cs(mw_cs), .mw_sk(mw_sk), .mw_di(mw_di),
        .mw_do(mw_do), .shift_busy(shift_busy), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .load_done(load_done), .load_fail(load_fail),
        .recover_i(recover_i), .irq_oe(irq_oe), .host_en(host_en)
    );

    always #10 clk = ~clk;

    int errs = 0;
    int checks = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- EEPROM model ----------------
    logic [15:0] img [TOT];
    bit          present = 1'b1;
    int          cmd_n = 0;
    logic [8:0]  cmd_got = '0;
    bit          dummy_done = 1'b0;
    int          out_pos = 0;
    logic        do_r = 1'b1;

    assign mw_do = present ? do_r : 1'b1;

    always @(posedge mw_sk) begin
        if (mw_cs && cmd_n < 9) begin
            cmd_got = {cmd_got[7:0], mw_di};
            cmd_n++;
        end
    end

    always @(negedge mw_sk) begin
        if (mw_cs && cmd_n == 9) begin
            if (!dummy_done) begin
                do_r = 1'b0;
                dummy_done = 1'b1;
            end else if (out_pos < TOT * 16) begin
                do_r = img[out_pos / 16][15 - (out_pos % 16)];
                out_pos++;
            end
        end
    end

    // ---------------- snoop monitor ----------------
    logic [15:0] snp [TOT];
    int          busy_rises = 0;
    logic        sk_prev = 1'b0;

    always @(negedge clk) begin
        if (mw_sk && !sk_prev && shift_busy) begin
            if (busy_rises < TOT * 16)
                snp[busy_rises / 16] = {snp[busy_rises / 16][14:0], mw_do};
            busy_rises++;
        end
        sk_prev = mw_sk;
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        int          addr;
        logic [15:0] data;
    } item_t;
    item_t sbq[$];
    int    writes = 0;

    always @(negedge clk) begin
        if (rst_n && cfg_we) begin
            writes++;
            if (sbq.size() == 0) begin
                check(1'b0, "R3", "write with nothing expected", 32'(cfg_addr), 32'hFFFF);
            end else begin
                item_t it;
                it = sbq.pop_front();
                check(32'(cfg_addr) == it.addr, "R2", "write address", 32'(cfg_addr), 32'(it.addr));
                check(cfg_wdata == it.data, "R2", "write data", 32'(cfg_wdata), 32'(it.data));
            end
        end
    end

    task automatic push_expected();
        for (int i = 0; i < CFG; i++) begin
            item_t it;
            it.addr = i;
            it.data = img[i];
            sbq.push_back(it);
        end
    endtask

    task automatic build_image(input logic [15:0] seed, input logic [15:0] bias);
        logic [15:0] s;
        s = '0;
        for (int i = 0; i < CFG - 1; i++) begin
            img[i] = 16'(i * 16'h1357) ^ seed;
            s = s + img[i];
        end
        img[CFG-1] = CHK - s + bias;
        img[TOT-1] = 16'hC0DE ^ seed;
    endtask

    task automatic run_load(input bit pres, input bit pass, input string tag);
        int n;
        rst_n = 1'b0;
        present = pres;
        cmd_n = 0; cmd_got = '0; dummy_done = 1'b0; out_pos = 0; do_r = 1'b1;
        busy_rises = 0; writes = 0;
        sbq.delete();
        for (int i = 0; i < TOT; i++) snp[i] = '0;
        if (pass) push_expected();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        n = 0;
        while (n < 200) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (mw_cs) break;
        end
        check(n == START * HALF, "R1", {tag, " clocks to chip select"}, 32'(n), 32'(START * HALF));
        repeat (100) @(negedge clk);
        check(mw_cs && !host_en, "R7", {tag, " host blocked during load"}, 32'(host_en), 32'h0);
        check(!irq_oe, "R6", {tag, " irq_oe low during load"}, 32'(irq_oe), 32'h0);
        n = 0;
        while (!(load_done || load_fail) && n < 10000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
        check(cmd_got == 9'b110_000000, "R8", {tag, " command bits"}, 32'(cmd_got), 32'h180);
        check(busy_rises == TOT * 16, "R5", {tag, " busy sampling edges"}, 32'(busy_rises), 32'(TOT * 16));
        for (int i = 0; i < TOT; i++) begin
            logic [15:0] e;
            e = pres ? img[i] : 16'hFFFF;
            check(snp[i] == e, "R5", {tag, " snooped word"}, 32'(snp[i]), 32'(e));
        end
        check(!mw_cs && !mw_sk, "R1", {tag, " interface idle after load"}, {mw_cs, mw_sk}, 32'h0);
        check(host_en, "R7", {tag, " host enabled after load"}, 32'(host_en), 32'h1);
        if (pass) begin
            check(load_done && !load_fail, "R4", {tag, " done flag"}, {load_done, load_fail}, 32'h2);
            check(writes == CFG, "R2", {tag, " write count excludes user word"}, 32'(writes), 32'(CFG));
            check(sbq.size() == 0, "R2", {tag, " all expected writes seen"}, 32'(sbq.size()), 32'h0);
            check(irq_oe, "R6", {tag, " irq_oe after success"}, 32'(irq_oe), 32'h1);
        end else begin
            check(load_fail && !load_done, "R4", {tag, " fail flag"}, {load_done, load_fail}, 32'h1);
            check(writes == 0, pres ? "R4" : "R9", {tag, " no writes on bad sum"}, 32'(writes), 32'h0);
            repeat (5) @(negedge clk);
            check(!irq_oe, "R6", {tag, " irq_oe held after fail"}, 32'(irq_oe), 32'h0);
            recover_i = 1'b1;
            @(negedge clk);
            recover_i = 1'b0;
            @(negedge clk);
            check(irq_oe, "R6", {tag, " irq_oe after recovery"}, 32'(irq_oe), 32'h1);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check({mw_cs, mw_sk, shift_busy, cfg_we, load_done, load_fail, irq_oe, host_en} == 8'h0,
              "R1", "reset state",
              32'({mw_cs, mw_sk, shift_busy, cfg_we, load_done, load_fail, irq_oe, host_en}), 32'h0);

        build_image(16'h0000, 16'h0000);
        run_load(1'b1, 1'b1, "imgA");                     // R2 R4 R5 R8

        build_image(16'hA5F0, 16'h0000);
        run_load(1'b1, 1'b1, "imgB");                     // R2 R4

        build_image(16'h3C3C, 16'h0001);
        run_load(1'b1, 1'b0, "sum_off_by_one");           // R4 R6

        build_image(16'h0000, 16'h0000);
        run_load(1'b0, 1'b0, "no_eeprom");                // R9

        report();
        $finish;
    end
endmodule